// File: doc/BRIEF.md
# Closed-Page DRAM Command Timing Scheduler

This block turns one read or write transaction at a time into a timed list of DRAM commands: bank activates, reads or writes, and reads or writes with auto-precharge. Each command comes out with the clock cycle at which it may legally be issued, its opcode and its bank. The block does not wait in real time. It works out the earliest legal cycle of every command from timing windows it keeps for each bank and for the device as a whole. The stream is handed downstream over a valid/ready handshake.

A transaction carries a type, a bank group and a bank within that group. It is spread over several banks (bank interleave), several back-to-back bursts per bank (burst count) and several bank groups (group interleave), all three set by static configuration inputs. Every bank is closed again at the end of the transaction: the last burst to each bank carries auto-precharge. All timing values are static inputs. When bank-group timing is enabled, the spacing and turnaround values switch between short and long settings depending on whether the bank group changes.

Top module: `dram_cmd_sched`

## Requirements
- R1: After reset, req_ready is 1 while busy and cmd_valid are 0. The cycle counter that stamps arrivals starts at 0 in the first cycle after reset and counts up by one every clock.
- R2: A request is taken at a clock edge where req_valid and req_ready are both 1, and its arrival cycle is the counter value at that edge. From the next cycle, busy is 1 and req_ready is 0 until the edge at which the transaction's last command is accepted.
- R3: Accesses are generated with the bank index i (0..cfg_banks-1) outermost, then the burst index k (0..cfg_bursts-1), then the group index j (0..cfg_groups-1). The access goes to cmd_bank = {req_group+j, req_bank+i}, each field wrapping at its own width. The first time a transaction touches a bank, an activate (op 0) comes out just before that access's read/write, and a bank is activated only once per transaction. A read or write is op 1 or 2. On the last burst (k = cfg_bursts-1) it becomes op 3 or op 4, with auto-precharge.
- R4: An activate time is the latest of three points, each counted only once it exists: the previous activate plus tRRD, the bank's last precharge plus tRP, and the fourth-most-recent activate plus tFAW. All three carry over across transactions.
- R5: For the first access of a transaction (i=j=k=0), the activate is also no earlier than the arrival cycle and no earlier than one cycle after the previous read/write.
- R6: If an activate lands on the same cycle as the most recent read/write of the current transaction, it moves one cycle later.
- R7: A read/write time is the later of two points: the previous read/write plus the switch delay, and the bank's activate plus tRCD.
- R8: The switch delay is tCCD when the type repeats. A write followed by a read uses WL+BL+tWTR, and a read followed by a write uses RL+BL+2-WL, where BL is the burst length in clocks.
- R9: With cfg_bg_mode at 1, the short tRRD applies when an activate's group differs from the previous activate's group. The short tCCD and tWTR apply when a read/write's group differs from the previous read/write's group. In every other case the long values apply.
- R10: An auto-precharge sets the bank's precharge time to the later of its activate plus tRAS and the read/write plus the recovery delay. The recovery delay is WL+BL+tWR after a write and tRTP after a read.
- R11: While cmd_valid is 1 and cmd_ready is 0, cmd_time, cmd_op and cmd_bank hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_bg_mode | input | 1 | Enables short/long bank-group timing |
| cfg_banks | input | CW | Banks interleaved per transaction (>=1) |
| cfg_bursts | input | CW | Bursts per bank (>=1) |
| cfg_groups | input | CW | Bank groups interleaved (>=1) |
| t_rrd_s | input | PW | Activate spacing, group change |
| t_rrd_l | input | PW | Activate spacing, same group |
| t_rp | input | PW | Precharge to activate |
| t_faw | input | PW | Four-activate window |
| t_rcd | input | PW | Activate to read/write |
| t_ras | input | PW | Activate to precharge |
| t_ccd_s | input | PW | Same-type spacing, group change |
| t_ccd_l | input | PW | Same-type spacing, same group |
| t_wtr_s | input | PW | Write-to-read, group change |
| t_wtr_l | input | PW | Write-to-read, same group |
| t_wr | input | PW | Write recovery |
| t_rtp | input | PW | Read to precharge |
| t_wl | input | PW | Write latency |
| t_rl | input | PW | Read latency |
| t_bl | input | PW | Burst length in clocks |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Block idle, can accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_group | input | GW | Starting bank group |
| req_bank | input | LBW | Starting bank within group |
| busy | output | 1 | Transaction in progress |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Downstream accepts command |
| cmd_time | output | TW | Cycle at which the command may issue |
| cmd_op | output | 3 | 0 ACT, 1 RD, 2 WR, 3 RD+AP, 4 WR+AP |
| cmd_bank | output | GW+LBW | Target bank {group, bank} |

## Verification
The first transaction after reset is checked against hand-computed cycles. That pins down the bare arrival and activate-to-read path, with no earlier history in play. Random transactions then mix reads and writes, starting groups and banks, gaps between arrivals and interleave/burst/group counts. Short gaps expose the precharge, four-activate and completion limits that carry over from one transaction to the next. Alternating types separate the three switch delays, and toggling bank-group mode with several groups tells the short settings from the long ones. A second phase with new timing values and a random cmd_ready stall pattern checks that the results do not depend on one timing set and that stalled commands hold steady.

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched #(
  parameter int GW  = 2,
  parameter int LBW = 2,
  parameter int CW  = 3,
  parameter int PW  = 6,
  parameter int TW  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bg_mode,
  input  logic [CW-1:0]     cfg_banks,
  input  logic [CW-1:0]     cfg_bursts,
  input  logic [CW-1:0]     cfg_groups,
  input  logic [PW-1:0]     t_rrd_s,
  input  logic [PW-1:0]     t_rrd_l,
  input  logic [PW-1:0]     t_rp,
  input  logic [PW-1:0]     t_faw,
  input  logic [PW-1:0]     t_rcd,
  input  logic [PW-1:0]     t_ras,
  input  logic [PW-1:0]     t_ccd_s,
  input  logic [PW-1:0]     t_ccd_l,
  input  logic [PW-1:0]     t_wtr_s,
  input  logic [PW-1:0]     t_wtr_l,
  input  logic [PW-1:0]     t_wr,
  input  logic [PW-1:0]     t_rtp,
  input  logic [PW-1:0]     t_wl,
  input  logic [PW-1:0]     t_rl,
  input  logic [PW-1:0]     t_bl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [GW-1:0]     req_group,
  input  logic [LBW-1:0]    req_bank,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [TW-1:0]     cmd_time,
  output logic [2:0]        cmd_op,
  output logic [GW+LBW-1:0] cmd_bank
);
  localparam int BW = GW + LBW;
  localparam int NB = 1 << BW;
  localparam logic [2:0] OP_ACT = 3'd0, OP_RD = 3'd1, OP_WR = 3'd2, OP_RDA = 3'd3, OP_WRA = 3'd4;

  typedef enum logic {S_IDLE, S_ACC} state_t;
  state_t st;

  logic [TW-1:0]  now, arr_q;
  logic           wr_q;
  logic [GW-1:0]  grp_q;
  logic [LBW-1:0] bnk_q;
  logic [CW-1:0]  ci, ck, cj;

  logic [TW-1:0]  act_t [NB];
  logic [TW-1:0]  pre_t [NB];
  logic [NB-1:0]  pre_v, act_done;

  logic [TW-1:0]  last_act_t, last_rw_t;
  logic [GW-1:0]  last_act_g, last_rw_g;
  logic           last_act_v, last_rw_v, last_rw_wr, txn_rw;

  logic [TW-1:0]  faw_t [4];
  logic [3:0]     faw_v;
  logic [1:0]     faw_p;

  function automatic logic [TW-1:0] mx(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [TW-1:0] ext(input logic [PW-1:0] p);
    return TW'(p);
  endfunction

  logic [GW-1:0]  cur_g;
  logic [LBW-1:0] cur_w;
  logic [BW-1:0]  cur_b;
  logic first, last_i, last_k, last_j, last_all, need_act, fire;
  logic act_short, rw_short;
  logic [PW-1:0]  rrd, ccd, wtr;
  logic [TW-1:0]  a0, a1, a2, a3, act_time, sw, rw_time, rec, pre_new;

  assign cur_g    = grp_q + GW'(cj);
  assign cur_w    = bnk_q + LBW'(ci);
  assign cur_b    = {cur_g, cur_w};
  assign first    = (ci == '0) && (ck == '0) && (cj == '0);
  assign last_i   = (ci == cfg_banks  - CW'(1));
  assign last_k   = (ck == cfg_bursts - CW'(1));
  assign last_j   = (cj == cfg_groups - CW'(1));
  assign last_all = last_i && last_k && last_j;
  assign need_act = !act_done[cur_b];

  assign act_short = cfg_bg_mode && last_act_v && (last_act_g != cur_g);
  assign rw_short  = cfg_bg_mode && last_rw_v  && (last_rw_g  != cur_g);
  assign rrd = act_short ? t_rrd_s : t_rrd_l;
  assign ccd = rw_short  ? t_ccd_s : t_ccd_l;
  assign wtr = rw_short  ? t_wtr_s : t_wtr_l;

  assign a0 = last_act_v ? last_act_t + ext(rrd) : '0;
  assign a1 = mx(a0, pre_v[cur_b] ? pre_t[cur_b] + ext(t_rp) : '0);
  assign a2 = mx(a1, faw_v[faw_p] ? faw_t[faw_p] + ext(t_faw) : '0);
  assign a3 = first ? mx(mx(a2, arr_q), last_rw_v ? last_rw_t + TW'(1) : '0) : a2;
  assign act_time = (txn_rw && (a3 == last_rw_t)) ? a3 + TW'(1) : a3;

  always_comb begin
    if (last_rw_wr == wr_q) sw = ext(ccd);
    else if (last_rw_wr)    sw = ext(t_wl) + ext(t_bl) + ext(wtr);
    else                    sw = ext(t_rl) + ext(t_bl) + TW'(2) - ext(t_wl);
  end

  assign rw_time = mx(last_rw_v ? last_rw_t + sw : '0, act_t[cur_b] + ext(t_rcd));
  assign rec     = wr_q ? ext(t_wl) + ext(t_bl) + ext(t_wr) : ext(t_rtp);
  assign pre_new = mx(act_t[cur_b] + ext(t_ras), rw_time + rec);

  assign req_ready = (st == S_IDLE);
  assign busy      = (st == S_ACC);
  assign cmd_valid = (st == S_ACC);
  assign cmd_time  = need_act ? act_time : rw_time;
  assign cmd_bank  = cur_b;
  assign cmd_op    = need_act ? OP_ACT :
                     wr_q ? (last_k ? OP_WRA : OP_WR) : (last_k ? OP_RDA : OP_RD);
  assign fire      = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      now <= '0;
      arr_q <= '0;
      wr_q <= 1'b0;
      grp_q <= '0;
      bnk_q <= '0;
      ci <= '0;
      ck <= '0;
      cj <= '0;
      pre_v <= '0;
      act_done <= '0;
      for (int b = 0; b < NB; b++) begin
        act_t[b] <= '0;
        pre_t[b] <= '0;
      end
      last_act_t <= '0;
      last_act_g <= '0;
      last_act_v <= 1'b0;
      last_rw_t <= '0;
      last_rw_g <= '0;
      last_rw_v <= 1'b0;
      last_rw_wr <= 1'b0;
      txn_rw <= 1'b0;
      for (int f = 0; f < 4; f++) faw_t[f] <= '0;
      faw_v <= '0;
      faw_p <= '0;
    end else begin
      now <= now + TW'(1);
      if (st == S_IDLE) begin
        if (req_valid) begin
          st <= S_ACC;
          arr_q <= now;
          wr_q <= req_write;
          grp_q <= req_group;
          bnk_q <= req_bank;
          ci <= '0;
          ck <= '0;
          cj <= '0;
          act_done <= '0;
          txn_rw <= 1'b0;
        end
      end else if (fire) begin
        if (need_act) begin
          act_t[cur_b] <= act_time;
          act_done[cur_b] <= 1'b1;
          last_act_t <= act_time;
          last_act_g <= cur_g;
          last_act_v <= 1'b1;
          faw_t[faw_p] <= act_time;
          faw_v[faw_p] <= 1'b1;
          faw_p <= faw_p + 2'd1;
        end else begin
          last_rw_t <= rw_time;
          last_rw_g <= cur_g;
          last_rw_v <= 1'b1;
          last_rw_wr <= wr_q;
          txn_rw <= 1'b1;
          if (last_k) begin
            pre_t[cur_b] <= pre_new;
            pre_v[cur_b] <= 1'b1;
          end
          if (last_all) st <= S_IDLE;
          if (!last_j) cj <= cj + CW'(1);
          else begin
            cj <= '0;
            if (!last_k) ck <= ck + CW'(1);
            else begin
              ck <= '0;
              ci <= ci + CW'(1);
            end
          end
        end
      end
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_time) && $stable(cmd_op) && $stable(cmd_bank)); // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready); // R2
  AST_FAW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == OP_ACT && (&faw_v) |-> cmd_time >= faw_t[faw_p] + ext(t_faw)); // R4
  AST_RW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op != OP_ACT && last_rw_v |-> cmd_time > last_rw_t); // R7
  AST_ACT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == OP_ACT |-> !act_done[cmd_bank]); // R3
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op != OP_ACT |-> act_done[cmd_bank] && cmd_time >= act_t[cmd_bank] + ext(t_rcd)); // R7
endmodule

// File: tb/tb_dram_cmd_sched.sv
`timescale 1ns/1ps
module tb_dram_cmd_sched;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic bgm = 1'b0;
  logic [2:0] nbk = 3'd1, nbu = 3'd1, ngr = 3'd1;
  logic [5:0] rrd_s, rrd_l, rp, faw, rcd, ras, ccd_s, ccd_l, wtr_s, wtr_l, twr, rtp, wl, rl, bl;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_group = '0, req_bank = '0;
  logic req_ready, busy, cmd_valid, cmd_ready = 1'b1;
  logic [19:0] cmd_time;
  logic [2:0] cmd_op;
  logic [3:0] cmd_bank;

  dram_cmd_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_bg_mode(bgm), .cfg_banks(nbk), .cfg_bursts(nbu), .cfg_groups(ngr),
    .t_rrd_s(rrd_s), .t_rrd_l(rrd_l), .t_rp(rp), .t_faw(faw), .t_rcd(rcd), .t_ras(ras),
    .t_ccd_s(ccd_s), .t_ccd_l(ccd_l), .t_wtr_s(wtr_s), .t_wtr_l(wtr_l), .t_wr(twr), .t_rtp(rtp),
    .t_wl(wl), .t_rl(rl), .t_bl(bl),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_group(req_group),
    .req_bank(req_bank), .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_time(cmd_time), .cmd_op(cmd_op), .cmd_bank(cmd_bank));

  int checks = 0, errors = 0;
  int tcyc = 0;
  bit stall_en = 1'b0, done = 1'b0;
  always @(posedge clk) if (!rst_n) tcyc <= 0; else tcyc <= tcyc + 1;

  int exp_t [0:4095]; int exp_o [0:4095]; int exp_b [0:4095];
  int ep = 0, gp = 0;

  int m_act_t [16]; int m_pre_t [16]; bit m_pre_v [16]; bit m_done [16];
  int m_la_t, m_la_g, m_lr_t, m_lr_g; bit m_la_v, m_lr_v, m_lr_w, m_txrw;
  int m_faw_t [4]; bit m_faw_v [4]; int m_fp;

  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 16; b++) begin m_act_t[b] = 0; m_pre_t[b] = 0; m_pre_v[b] = 0; m_done[b] = 0; end
    for (int f = 0; f < 4; f++) begin m_faw_t[f] = 0; m_faw_v[f] = 0; end
    m_fp = 0; m_la_v = 0; m_lr_v = 0; m_la_t = 0; m_la_g = 0; m_lr_t = 0; m_lr_g = 0; m_lr_w = 0;
    ep = 0; gp = 0;
  endtask

  task automatic push(int t, int o, int b);
    exp_t[ep] = t; exp_o[ep] = o; exp_b[ep] = b; ep++;
  endtask

  task automatic model_txn(bit w, int g, int b, int arr);
    for (int b2 = 0; b2 < 16; b2++) m_done[b2] = 0;
    m_txrw = 0;
    for (int i = 0; i < nbk; i++)
      for (int k = 0; k < nbu; k++)
        for (int j = 0; j < ngr; j++) begin
          int cg, cb, t, sw, rt, cc, wt;
          cg = (g + j) % 4;
          cb = cg * 4 + (b + i) % 4;
          if (!m_done[cb]) begin
            t = m_la_v ? m_la_t + ((bgm && m_la_g != cg) ? rrd_s : rrd_l) : 0;   // R9
            if (m_pre_v[cb]) t = mx(t, m_pre_t[cb] + rp);                         // R10
            if (m_faw_v[m_fp]) t = mx(t, m_faw_t[m_fp] + faw);                    // R4
            if (i == 0 && k == 0 && j == 0) begin                                  // R5
              t = mx(t, arr);
              if (m_lr_v) t = mx(t, m_lr_t + 1);
            end
            if (m_txrw && t == m_lr_t) t = t + 1;                                  // R6
            push(t, 0, cb);
            m_act_t[cb] = t; m_done[cb] = 1; m_la_t = t; m_la_g = cg; m_la_v = 1;
            m_faw_t[m_fp] = t; m_faw_v[m_fp] = 1; m_fp = (m_fp + 1) % 4;
          end
          cc = (bgm && m_lr_v && m_lr_g != cg) ? ccd_s : ccd_l;
          wt = (bgm && m_lr_v && m_lr_g != cg) ? wtr_s : wtr_l;
          if (m_lr_w == w) sw = cc;                                                // R8
          else if (m_lr_w) sw = wl + bl + wt;
          else sw = rl + bl + 2 - wl;
          rt = m_act_t[cb] + rcd;                                                  // R7
          if (m_lr_v) rt = mx(rt, m_lr_t + sw);
          push(rt, (k == nbu - 1) ? (w ? 4 : 3) : (w ? 2 : 1), cb);               // R3
          m_lr_t = rt; m_lr_g = cg; m_lr_v = 1; m_lr_w = w; m_txrw = 1;
          if (k == nbu - 1) begin
            m_pre_t[cb] = mx(m_act_t[cb] + ras, rt + (w ? wl + bl + twr : rtp));
            m_pre_v[cb] = 1;
          end
        end
  endtask

  logic [19:0] h_t; logic [2:0] h_o; logic [3:0] h_b; bit h_v = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (h_v) begin
        chk(cmd_valid && cmd_time == h_t && cmd_op == h_o && cmd_bank == h_b, "R11 hold", int'(cmd_time), int'(h_t));
      end
      cmd_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
      h_v = cmd_valid && !cmd_ready;
      h_t = cmd_time; h_o = cmd_op; h_b = cmd_bank;
      if (cmd_valid && cmd_ready) begin
        if (gp >= ep) chk(1'b0, "R3 extra command", gp, ep);
        else begin
          chk(int'(cmd_op) == exp_o[gp], "R3 opcode", int'(cmd_op), exp_o[gp]);
          chk(int'(cmd_bank) == exp_b[gp], "R3 bank", int'(cmd_bank), exp_b[gp]);
          chk(int'(cmd_time) == exp_t[gp], (exp_o[gp] == 0) ? "R4 R5 R6 R9 R10 act time" : "R7 R8 R9 rw time",
              int'(cmd_time), exp_t[gp]);
        end
        gp++;
      end
    end else h_v = 0;
  end

  task automatic run_txn(bit w, int g, int b, int gap, output int arr);
    repeat (gap) @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_write = w; req_group = 2'(g); req_bank = 2'(b); req_valid = 1'b1;
    arr = tcyc;
    model_txn(w, g, b, arr);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R2 busy after accept", int'(busy), 1);
    while (!req_ready) @(negedge clk);
    chk(!busy && gp == ep, "R2 idle after last command", gp, ep);
  endtask

  task automatic set_default_timing();
    rrd_s = 2; rrd_l = 3; rp = 5; faw = 12; rcd = 4; ras = 9; ccd_s = 2; ccd_l = 3;
    wtr_s = 2; wtr_l = 4; twr = 5; rtp = 3; wl = 3; rl = 5; bl = 2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !cmd_valid, "R1 reset state", int'(req_ready), 1);
  endtask

  task automatic random_phase(int n);
    int arr;
    for (int t = 0; t < n; t++) begin
      bgm = 1'($urandom % 2);
      nbk = 3'(1 + $urandom % 4); nbu = 3'(1 + $urandom % 3); ngr = 3'(1 + $urandom % 3);
      run_txn(1'($urandom % 2), int'($urandom % 4), int'($urandom % 4), int'($urandom % 12), arr);
    end
  endtask

  initial begin
    int arr, a0;
    void'($urandom(32'd20250611));
    set_default_timing();
    do_reset();
    // Directed: first transaction, plain read, no history (R5, R7, R3)
    run_txn(1'b0, 0, 0, 2, a0);
    chk(exp_t[0] == a0 && exp_t[1] == a0 + 4 && exp_o[1] == 3, "R5 R7 directed first read", exp_t[1], a0 + 4);
    // Directed: write to same bank right away, limited by precharge a0+9 plus tRP (R10)
    run_txn(1'b1, 0, 0, 0, arr);
    chk(exp_t[2] == mx(a0 + 14, arr), "R10 directed reopen", exp_t[2], mx(a0 + 14, arr));
    // Directed: six activates in one transaction exercise the four-activate window (R4)
    nbk = 3; ngr = 2; nbu = 1; bgm = 1;
    run_txn(1'b0, 1, 2, 0, arr);
    // Directed: alternating types with several bursts (R8, R9)
    nbk = 1; nbu = 3; ngr = 3;
    run_txn(1'b1, 3, 1, 0, arr);
    run_txn(1'b0, 2, 3, 0, arr);
    nbk = 1; nbu = 1; ngr = 1;
    random_phase(60);
    // Phase two: other timing set, stalled output
    rrd_s = 1; rrd_l = 4; rp = 3; faw = 16; rcd = 2; ras = 6; ccd_s = 1; ccd_l = 4;
    wtr_s = 1; wtr_l = 6; twr = 3; rtp = 5; wl = 6; rl = 4; bl = 4;
    stall_en = 1'b1;
    do_reset();
    random_phase(60);
    stall_en = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", gp, ep);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule